// File: doc/BRIEF.md
# DDR SDRAM command sequencer

This block sits on the controller side of a four-bank DDR SDRAM. It takes one read or write request at a time through a valid/ready handshake. Each request carries a bank, row, column, direction and an auto-precharge flag. The block turns the request into the command sequence the memory needs, and puts out at most one command per clock on a command bus that the memory samples on the rising edge.

The block remembers the open row of every bank, so banks the current request does not touch keep their rows open. For each request it picks one of three paths:
- A row hit goes straight to the column command.
- A closed bank first gets an Activate.
- A bank open on another row is precharged, then activated.

When auto-precharge is requested, the bank is marked closed once the column command goes out, and the block spaces the next Activate to that bank as the self-timed precharge needs.

A refresh timer raises a refresh demand at a fixed interval. While the demand is pending, new requests are refused. All open banks are closed with one precharge-all command, then a single auto-refresh command covers all four banks. A read-return strobe marks the cycle in which read data is due, derived from the configured CAS latency.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset, `cmd` is NOP and `req_ready` is high, and all four banks are treated as closed. The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6.
- R2: A request to a closed bank produces ACT carrying the requested bank and row on `cmd_addr`. The column command follows no earlier than T_RCD cycles after that ACT.
- R3: A request to a bank whose open row differs from the requested row produces PRE to that bank, then ACT no earlier than T_RP cycles later, then the column command.
- R4: A request whose row is already open in its bank produces no ACT and no PRE. RD (or WR when the direction bit is 1) carries the column in the low bits of `cmd_addr` and the auto-precharge flag on `cmd_ap`. Rows open in other banks are left open.
- R5: Two column commands are never closer than BL/2 cycles. PRE and PREA also wait until the previous burst has drained.
- R6: After a column command with `cmd_ap`=1, no PRE is issued for that bank. Its next access starts with ACT, no earlier than BL/2+T_RP cycles after the column command.
- R7: Every REF_INT cycles a refresh becomes pending. Once any accepted request has finished, the block issues PREA if any bank is open, then REF after T_RP. No command follows REF for T_RFC cycles. While a refresh is pending, `req_ready` stays low.
- R8: `rd_return` pulses for one cycle exactly ceil(CL) cycles after each RD, where CL = CL_X2/2.
- R9: `req_ready` falls in the cycle after a request is accepted. It stays low until the cycle after that request's column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands take effect on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row automatically after the burst |
| cmd | output | 3 | Command code (see R1) |
| cmd_bank | output | 2 | Bank addressed by ACT, PRE, RD or WR |
| cmd_addr | output | ROW_W | Row for ACT, column for RD/WR, zero otherwise |
| cmd_ap | output | 1 | Auto-precharge flag of a column command |
| rd_return | output | 1 | Read data is due this cycle |

## Verification
A wrong open-row entry for a bank shows up at the next request to that bank. The sequence then carries an extra or a missing PRE/ACT, which a per-cycle comparison catches on the first command that differs. A timing counter loaded with the wrong value moves a command by one or more cycles, so the mismatch appears in the cycle the command should have gone out. A lost refresh demand keeps `req_ready` high where the reference expects it low, which is visible within one refresh interval.

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int BL      = 4,
  parameter int CL_X2   = 5,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int REF_INT = 1560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic             req_ap,
  output logic [2:0]       cmd,
  output logic [1:0]       cmd_bank,
  output logic [ROW_W-1:0] cmd_addr,
  output logic             cmd_ap,
  output logic             rd_return
);
  localparam int BEATS = BL / 2;
  localparam int CLC   = (CL_X2 + 1) / 2;
  localparam int CW    = 8;
  localparam int RIW   = $clog2(REF_INT + 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PREA = 3'd5, C_REF = 3'd6;

  logic             busy, q_wr, q_ap, ref_pend;
  logic [1:0]       q_bank;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;
  logic [3:0]       open_b;
  logic [ROW_W-1:0] orow [4];
  logic [CW-1:0]    bcnt [4];
  logic [CW-1:0]    burst;
  logic [RIW-1:0]   rtimer;
  logic [CLC-1:0]   rpipe;
  logic             all_idle, b_idle, col;

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < 4; b++) if (bcnt[b] != 0) all_idle = 1'b0;
  end

  assign b_idle    = (bcnt[q_bank] == 0);
  assign req_ready = !busy && !ref_pend;
  assign col       = (cmd == C_RD) || (cmd == C_WR);
  assign rd_return = rpipe[CLC-1];
  assign cmd_bank  = busy ? q_bank : 2'd0;
  assign cmd_ap    = col && q_ap;
  assign cmd_addr  = (cmd == C_ACT) ? q_row :
                     col ? {{(ROW_W-COL_W){1'b0}}, q_col} : '0;

  always_comb begin
    cmd = C_NOP;
    if (busy) begin
      if (!open_b[q_bank]) begin
        if (b_idle) cmd = C_ACT;
      end else if (orow[q_bank] != q_row) begin
        if (b_idle && burst == 0) cmd = C_PRE;
      end else if (b_idle && burst == 0) begin
        cmd = q_wr ? C_WR : C_RD;
      end
    end else if (ref_pend && all_idle && burst == 0) begin
      cmd = (|open_b) ? C_PREA : C_REF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; q_wr <= 1'b0; q_ap <= 1'b0; q_bank <= '0;
      q_row <= '0; q_col <= '0; open_b <= '0; burst <= '0;
      ref_pend <= 1'b0; rpipe <= '0;
      rtimer <= RIW'(REF_INT - 1);
      for (int b = 0; b < 4; b++) begin
        orow[b] <= '0;
        bcnt[b] <= '0;
      end
    end else begin
      rpipe <= {rpipe, 1'b0} | CLC'(cmd == C_RD);
      if (burst != 0) burst <= burst - 1'b1;
      for (int b = 0; b < 4; b++) if (bcnt[b] != 0) bcnt[b] <= bcnt[b] - 1'b1;
      case (cmd)
        C_ACT: begin
          open_b[q_bank] <= 1'b1;
          orow[q_bank]   <= q_row;
          bcnt[q_bank]   <= CW'(T_RCD - 1);
        end
        C_PRE: begin
          open_b[q_bank] <= 1'b0;
          bcnt[q_bank]   <= CW'(T_RP - 1);
        end
        C_RD, C_WR: begin
          busy  <= 1'b0;
          burst <= CW'(BEATS - 1);
          if (q_ap) begin
            open_b[q_bank] <= 1'b0;
            bcnt[q_bank]   <= CW'(BEATS + T_RP - 1);
          end
        end
        C_PREA: begin
          open_b <= '0;
          for (int b = 0; b < 4; b++) bcnt[b] <= CW'(T_RP - 1);
        end
        C_REF: begin
          ref_pend <= 1'b0;
          for (int b = 0; b < 4; b++) bcnt[b] <= CW'(T_RFC - 1);
        end
        default: ;
      endcase
      if (rtimer == 0) begin
        rtimer   <= RIW'(REF_INT - 1);
        ref_pend <= 1'b1;
      end else begin
        rtimer <= rtimer - 1'b1;
      end
      if (req_valid && req_ready) begin
        busy   <= 1'b1;
        q_bank <= req_bank;
        q_row  <= req_row;
        q_col  <= req_col;
        q_wr   <= req_write;
        q_ap   <= req_ap;
      end
    end
  end

  p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_col_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (BEATS > 1 && col) |=> !col);
  p_ref_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> (open_b == 4'd0));
  p_ap_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col && cmd_ap) |=> !open_b[$past(cmd_bank)]);
  p_rd_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_return |-> $past(cmd == C_RD, CLC));
endmodule

// File: tb/ddr_cmd_seq_test.sv
`timescale 1ns/1ps
module ddr_cmd_seq_test;
  localparam int ROW_W = 12, COL_W = 9, BL = 4, CL_X2 = 5;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, REF_INT = 300;
  localparam int BEATS = BL / 2, CLC = (CL_X2 + 1) / 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ap = 0;
  logic [1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_ready, cmd_ap, rd_return;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BL(BL), .CL_X2(CL_X2), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RFC(T_RFC), .REF_INT(REF_INT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_ap(req_ap), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_ap(cmd_ap), .rd_return(rd_return));

  // reference model: absolute cycle times, not counters
  int now, free_at[4], burst_at, mrow[4], tick, n_ref, n_pre, n_apcol, n_rd, n_ret;
  bit mopen[4], mbusy, pend;
  int qb, qr, qc; bit qw, qa;
  int ret_q[$];

  task automatic model_reset();
    now = 0; burst_at = 0; mbusy = 0; pend = 0; tick = REF_INT - 1;
    for (int b = 0; b < 4; b++) begin free_at[b] = 0; mopen[b] = 0; mrow[b] = 0; end
    ret_q.delete();
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, now, act, exp);
    end
  endtask

  function automatic string tag_of(int c);
    case (c)
      1: return "R2";
      4: return "R3";
      2, 3: return "R4";
      5, 6: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int e; bit all_ok, any_open, er, eret; string t;
      e = 0; all_ok = 1; any_open = 0;
      for (int b = 0; b < 4; b++) begin
        if (now < free_at[b]) all_ok = 0;
        if (mopen[b]) any_open = 1;
      end
      if (mbusy) begin
        if (!mopen[qb]) begin if (now >= free_at[qb]) e = 1; end
        else if (mrow[qb] != qr) begin if (now >= free_at[qb] && now >= burst_at) e = 4; end
        else if (now >= free_at[qb] && now >= burst_at) e = qw ? 3 : 2;
      end else if (pend && all_ok && now >= burst_at) e = any_open ? 5 : 6;
      er = !mbusy && !pend;
      eret = (ret_q.size() > 0 && ret_q[0] == now);
      if (eret) void'(ret_q.pop_front());
      t = tag_of(e);
      chk(cmd == 3'(e), t, cmd, e);
      if (e >= 1 && e <= 4) chk(cmd_bank == 2'(qb), t, cmd_bank, qb);
      if (e == 1) chk(cmd_addr == ROW_W'(qr), "R2", cmd_addr, qr);
      if (e == 2 || e == 3) begin
        chk(cmd_addr == ROW_W'(qc), "R4", cmd_addr, qc);
        chk(cmd_ap == qa, "R6", cmd_ap, qa);
      end
      chk(req_ready == er, "R9", req_ready, er);
      chk(rd_return == eret, "R8", rd_return, eret);
      if (rd_return) n_ret++;
      // advance model across the coming edge
      case (e)
        1: begin mopen[qb] = 1; mrow[qb] = qr; free_at[qb] = now + T_RCD; end
        4: begin mopen[qb] = 0; free_at[qb] = now + T_RP; n_pre++; end
        2, 3: begin
          mbusy = 0; burst_at = now + BEATS;
          if (e == 2) begin ret_q.push_back(now + CLC); n_rd++; end
          if (qa) begin mopen[qb] = 0; free_at[qb] = now + BEATS + T_RP; n_apcol++; end
        end
        5: for (int b = 0; b < 4; b++) begin mopen[b] = 0; free_at[b] = now + T_RP; end
        6: begin pend = 0; n_ref++; for (int b = 0; b < 4; b++) free_at[b] = now + T_RFC; end
        default: ;
      endcase
      if (tick == 0) begin pend = 1; tick = REF_INT - 1; end else tick--;
      if (req_valid && er) begin
        mbusy = 1; qb = req_bank; qr = req_row; qc = req_col; qw = req_write; qa = req_ap;
      end
      now++;
    end
  end

  task automatic req(int b, int r, int c, bit w, bit ap);
    req_valid = 1; req_bank = 2'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    req_write = w; req_ap = ap;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    n_ref = 0; n_pre = 0; n_apcol = 0; n_rd = 0; n_ret = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd == 3'd0, "R1", cmd, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    @(posedge clk); #1 rst_n = 1;
    req(0, 5, 8, 0, 0);            // R2 closed bank
    req(0, 5, 16, 1, 0);           // R4 hit
    req(0, 5, 24, 0, 0);           // R5 back to back
    req(1, 7, 3, 0, 0);            // R4 other bank, bank 0 stays open
    req(0, 5, 40, 0, 0);           // R4 hit on bank 0
    req(0, 9, 2, 1, 0);            // R3 miss
    req(2, 1, 1, 0, 1);            // R6 auto-precharge
    req(2, 1, 5, 0, 0);            // R6 reactivation
    idle(20);
    for (int i = 0; i < 120; i++) begin
      req(i % 4, (i * 7) % 5, (i * 13) % 512, i % 3 == 0, i % 5 == 0);
      if (i % 9 == 0) idle(i % 7);
    end
    idle(REF_INT + 40);            // R7 refresh while idle
    idle(20);
    chk(n_ref >= 2, "R7", n_ref, 2);
    chk(n_pre >= 1, "R3", n_pre, 1);
    chk(n_apcol >= 2, "R6", n_apcol, 2);
    chk(n_ret == n_rd, "R8", n_ret, n_rd);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cyc < 150000 && !done) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule